// File: doc/BRIEF.md
# Scanline-Paced Tone and Noise Shifter

This block is the one-bit sound source of a video controller. Software loads a 24-bit pattern as three bytes and writes a control byte. The block then moves the pattern toward its output one bit at a time. The pace comes from the controller's per-scanline tick: one step every 4 lines in the fast rate, or every 16 lines in the slow rate. The current output bit drives a 4-bit sample equal to the programmed volume, or zero.

A rotate mode feeds each departing bit back in at the top, so a 24-step pattern repeats for as long as the mode is on. A noise mode replaces the pattern bit with the low bit of a 16-bit maximal-length LFSR, which steps at the same rate. When 24 non-rotating steps have passed since the last pattern write, the block raises an empty flag. A sound interrupt request follows that flag, gated by an enable input that comes from the controller's own control register.

Top module: `tone_noise_shifter`

## Requirements
- R1: A write with `wr_en` high loads `wr_data` on the next rising edge. Address 0 holds pattern bits 7:0, address 1 holds bits 15:8, address 2 holds bits 23:16, and address 3 holds the control byte.
- R2: Each step moves the pattern one place toward bit 0, and pattern bit 0 is the current tone bit. Outside rotate mode, bit 23 is filled with 0.
- R3: Control bit 5 selects the rate. With bit 5 at 1, a step happens on every 4th `line_tick`; with bit 5 at 0, on every 16th. The tick count advances only while control bit 7 is 1 and restarts after each step. A step occurs on a tick that finds the count at or above the divisor minus one.
- R4: With control bit 6 at 1, the bit leaving position 0 re-enters at bit 23. Rotating steps do not advance the empty count.
- R5: With control bit 4 at 1, the tone bit is bit 0 of a 16-bit Galois LFSR. The LFSR shifts right and XORs mask 0xB400 into the result when the departing bit is 1. It resets to 0x0001 and advances on every step, whatever the value of bit 4.
- R6: `sample` equals control bits 3:0 when control bit 7 is 1 and the tone bit is 1; otherwise it is 0. While bit 7 is 0, neither the pattern nor the LFSR moves.
- R7: `empty` is 1 after reset. It goes to 1 on the 24th non-rotating step after the last pattern-byte write, and any pattern-byte write clears it. Control writes leave it unchanged.
- R8: `irq` is 1 exactly when `empty` is 1 and `irq_en` is 1.
- R9: In a cycle with neither `line_tick` nor `wr_en`, `sample` and `empty` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_tick | input | 1 | One-cycle pulse per scanline |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 to 2 pattern bytes, 3 control |
| wr_data | input | 8 | Write data |
| irq_en | input | 1 | Sound interrupt enable from the controller |
| sample | output | 4 | Scaled audio sample |
| empty | output | 1 | Pattern exhausted flag |
| irq | output | 1 | Sound interrupt request |

## Verification
Every result is due one clock edge after its stimulus. A write or a tick that completes a divisor period changes `sample` and `empty` at the next rising edge. `irq` follows `irq_en` at once and follows `empty` at that same edge. The driver changes inputs just after a falling edge and pushes the result its reference model expects just after the following rising edge. The monitor pops and compares at the next falling edge, so every comparison sees settled values of the cycle the expectation describes.

// File: rtl/tsg_pkg.sv
package tsg_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned VOL_W  = 4;

    // Field order matches the control byte, most significant bit first.
    typedef struct packed {
        logic             on;
        logic             rotate;
        logic             fast;
        logic             noise;
        logic [VOL_W-1:0] vol;
    } ctrl_t;
endpackage

// File: rtl/tsg_rate_div.sv
module tsg_rate_div #(
    parameter int unsigned FAST_DIV = 4,
    parameter int unsigned SLOW_DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic run,
    input  logic fast,
    output logic step
);
    localparam int unsigned CNT_W = $clog2(SLOW_DIV);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_st_t;

    div_st_t          st_d, st_q;
    logic [CNT_W-1:0] last_d;

    always_comb begin
        st_d   = st_q;
        step   = 1'b0;
        last_d = fast ? CNT_W'(FAST_DIV - 1) : CNT_W'(SLOW_DIV - 1);
        if (run && tick) begin
            if (st_q.cnt >= last_d) begin
                st_d.cnt = '0;
                step     = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tsg_pattern_shift.sv
module tsg_pattern_shift import tsg_pkg::*; #(
    parameter int unsigned PAT_BYTES = 3,
    localparam int unsigned IDX_W    = $clog2(PAT_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [IDX_W-1:0]  load_idx,
    input  logic [BYTE_W-1:0] load_byte,
    input  logic              step,
    input  logic              rotate,
    output logic              pat_bit,
    output logic              empty
);
    localparam int unsigned PAT_W = PAT_BYTES * BYTE_W;
    localparam int unsigned CNT_W = $clog2(PAT_W + 1);

    typedef struct packed {
        logic [PAT_W-1:0] pat;
        logic [CNT_W-1:0] cnt;
        logic             empty;
    } sh_st_t;

    sh_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            for (int i = 0; i < int'(PAT_BYTES); i++) begin
                if (load_idx == IDX_W'(i)) st_d.pat[i*BYTE_W +: BYTE_W] = load_byte;
            end
            st_d.cnt   = '0;
            st_d.empty = 1'b0;
        end else if (step) begin
            st_d.pat = {(rotate ? st_q.pat[0] : 1'b0), st_q.pat[PAT_W-1:1]};
            if (!rotate && !st_q.empty) begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
                if (st_q.cnt == CNT_W'(PAT_W - 1)) st_d.empty = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pat   <= '0;
            st_q.cnt   <= CNT_W'(PAT_W);
            st_q.empty <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign pat_bit = st_q.pat[0];
    assign empty   = st_q.empty;
endmodule

// File: rtl/tsg_noise_lfsr.sv
module tsg_noise_lfsr #(
    parameter int unsigned      LFSR_W = 16,
    parameter logic [LFSR_W-1:0] TAPS  = 'hB400,
    parameter logic [LFSR_W-1:0] SEED  = 'h0001
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output logic noise_bit
);
    typedef struct packed {
        logic [LFSR_W-1:0] lfsr;
    } lf_st_t;

    lf_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step) st_d.lfsr = (st_q.lfsr >> 1) ^ (st_q.lfsr[0] ? TAPS : '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.lfsr <= SEED;
        else        st_q      <= st_d;
    end

    assign noise_bit = st_q.lfsr[0];
endmodule

// File: rtl/tone_noise_shifter.sv
module tone_noise_shifter import tsg_pkg::*; #(
    parameter int unsigned PAT_BYTES = 3,
    parameter int unsigned FAST_DIV  = 4,
    parameter int unsigned SLOW_DIV  = 16,
    parameter int unsigned LFSR_W    = 16,
    localparam int unsigned ADDR_W   = $clog2(PAT_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              irq_en,
    output logic [VOL_W-1:0]  sample,
    output logic              empty,
    output logic              irq
);
    localparam int unsigned IDX_W = $clog2(PAT_BYTES);

    typedef struct packed {
        ctrl_t ctrl;
    } top_st_t;

    top_st_t st_d, st_q;
    ctrl_t   ctrl_q;
    logic    pat_load, step_w, pat_bit_w, noise_bit_w, empty_w, tone_bit;

    always_comb begin
        st_d     = st_q;
        pat_load = wr_en && (wr_addr < ADDR_W'(PAT_BYTES));
        if (wr_en && (wr_addr == ADDR_W'(PAT_BYTES))) st_d.ctrl = ctrl_t'(wr_data);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_q = st_q.ctrl;

    tsg_rate_div #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (line_tick),
        .run   (ctrl_q.on),
        .fast  (ctrl_q.fast),
        .step  (step_w)
    );

    tsg_pattern_shift #(.PAT_BYTES(PAT_BYTES)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (pat_load),
        .load_idx  (wr_addr[IDX_W-1:0]),
        .load_byte (wr_data),
        .step      (step_w),
        .rotate    (ctrl_q.rotate),
        .pat_bit   (pat_bit_w),
        .empty     (empty_w)
    );

    tsg_noise_lfsr #(.LFSR_W(LFSR_W)) u_noise (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step_w),
        .noise_bit (noise_bit_w)
    );

    always_comb begin
        tone_bit = ctrl_q.noise ? noise_bit_w : pat_bit_w;
        sample   = (ctrl_q.on && tone_bit) ? ctrl_q.vol : '0;
        empty    = empty_w;
        irq      = empty_w && irq_en;
    end
endmodule

// File: rtl/tsg_checker.sv
module tsg_checker import tsg_pkg::*; #(
    parameter int unsigned PAT_BYTES = 3,
    parameter int unsigned ADDR_W    = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              line_tick,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              irq_en,
    input logic [VOL_W-1:0]  sample,
    input logic              empty,
    input logic              irq,
    input ctrl_t             ctrl
);
    logic pat_wr;
    assign pat_wr = wr_en && (wr_addr < ADDR_W'(PAT_BYTES));

    a_r6_silent_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.on |-> (sample == '0));

    a_r6_level_is_volume: assert property (@(posedge clk) disable iff (!rst_n)
        (sample == '0) || (sample == ctrl.vol));

    a_r7_write_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pat_wr |=> !empty);

    a_r7_empty_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !pat_wr) |=> empty);

    a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    a_r8_irq_raised: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && irq_en) |-> irq);

    a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_tick && !wr_en) |=> ($stable(sample) && $stable(empty)));
endmodule

bind tone_noise_shifter tsg_checker #(.PAT_BYTES(PAT_BYTES), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_tick (line_tick),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .irq_en    (irq_en),
    .sample    (sample),
    .empty     (empty),
    .irq       (irq),
    .ctrl      (ctrl_q)
);

// File: tb/tone_noise_shifter_tb.sv
module tone_noise_shifter_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       irq_en = 1'b0;
    logic [3:0] sample;
    logic       empty;
    logic       irq;

    always #10 clk = ~clk;

    tone_noise_shifter u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_tick (line_tick),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .irq_en    (irq_en),
        .sample    (sample),
        .empty     (empty),
        .irq       (irq)
    );

    typedef struct {
        string      tag;
        logic [3:0] s;
        logic       e;
        logic       q;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;

    // Reference model state, kept from the requirements.
    logic [23:0] m_pat   = '0;
    int          m_cnt   = 24;
    logic        m_empty = 1'b1;
    logic [15:0] m_lfsr  = 16'h0001;
    int          m_div   = 0;
    logic [7:0]  m_ctrl  = '0;

    task automatic model_edge(input logic tk, input logic we, input logic [1:0] a,
                              input logic [7:0] d);
        int   lim;
        logic stp;
        logic ob;
        lim = m_ctrl[5] ? 3 : 15;                       // R3
        stp = m_ctrl[7] && tk && (m_div >= lim);
        if (m_ctrl[7] && tk) m_div = stp ? 0 : m_div + 1;
        if (we && a < 2'd3) begin                      // R1, R7
            m_pat[int'(a)*8 +: 8] = d;
            m_cnt   = 0;
            m_empty = 1'b0;
        end else if (stp) begin                        // R2, R4
            ob    = m_pat[0];
            m_pat = {(m_ctrl[6] ? ob : 1'b0), m_pat[23:1]};
            if (!m_ctrl[6] && !m_empty) begin
                m_cnt++;
                if (m_cnt == 24) m_empty = 1'b1;
            end
        end
        if (stp) m_lfsr = (m_lfsr >> 1) ^ (m_lfsr[0] ? 16'hB400 : 16'h0000); // R5
        if (we && a == 2'd3) m_ctrl = d;
    endtask

    function automatic exp_t model_out(input string tag);
        exp_t x;
        logic b;
        b     = m_ctrl[4] ? m_lfsr[0] : m_pat[0];
        x.tag = tag;
        x.s   = (m_ctrl[7] && b) ? m_ctrl[3:0] : 4'd0;  // R6
        x.e   = m_empty;
        x.q   = m_empty && irq_en;                      // R8
        return x;
    endfunction

    // Driver: one clock cycle of stimulus, then the expectation for it.
    task automatic cyc(input logic tk, input logic we, input logic [1:0] a,
                       input logic [7:0] d, input logic ie, input string tag);
        @(negedge clk);
        #1;
        line_tick = tk;
        wr_en     = we;
        wr_addr   = a;
        wr_data   = d;
        irq_en    = ie;
        @(posedge clk);
        #1;
        model_edge(tk, we, a, d);
        exp_q.push_back(model_out(tag));
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d, input string tag);
        cyc(1'b0, 1'b1, a, d, 1'b1, tag);
    endtask

    task automatic run(input int n, input int gap, input string tag);
        for (int i = 0; i < n; i++) begin
            cyc(1'b1, 1'b0, 2'd0, 8'd0, 1'b1, tag);
            for (int g = 0; g < gap; g++) cyc(1'b0, 1'b0, 2'd0, 8'd0, 1'b1, {tag, " R9"});
        end
    endtask

    // Monitor: compare at the falling edge after each expectation.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (sample !== e.s || empty !== e.e || irq !== e.q) begin
                errors++;
                $display("FAIL %s: sample=%0d empty=%0b irq=%0b expected sample=%0d empty=%0b irq=%0b",
                         e.tag, sample, empty, irq, e.s, e.e, e.q);
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // Reset state, interrupt gated off then on
        cyc(1'b0, 1'b0, 2'd0, 8'd0, 1'b0, "R7 reset empty, R8 gated");
        cyc(1'b0, 1'b0, 2'd0, 8'd0, 1'b1, "R8 irq with empty");
        // Ticks while off do nothing
        run(8, 0, "R6 off before enable");
        // Pattern load, byte order
        wr(2'd0, 8'h96, "R1 byte0 R7 clear");
        wr(2'd1, 8'h3C, "R1 byte1");
        wr(2'd2, 8'hA5, "R1 byte2");
        wr(2'd3, 8'hA9, "R1 ctrl fast vol9");
        // Fast rate, full drain and beyond
        run(24 * 4 + 12, 0, "R2 R3 fast drain R7");
        run(12, 1, "R3 gapped ticks");
        // Control write leaves empty untouched
        wr(2'd3, 8'hA3, "R7 ctrl write keeps empty");
        // Reload one byte then slow rate
        wr(2'd1, 8'hF0, "R7 reload clears");
        wr(2'd3, 8'h89, "R1 ctrl slow");
        run(24 * 16 + 20, 0, "R3 slow drain R7");
        // Switch to fast mid-pattern
        wr(2'd0, 8'h5B, "R1 reload");
        run(7, 0, "R3 slow partial");
        wr(2'd3, 8'hA6, "R3 switch fast");
        run(40, 0, "R3 after switch");
        // Rotate
        wr(2'd0, 8'h01, "R4 load");
        wr(2'd1, 8'h80, "R4 load");
        wr(2'd2, 8'h33, "R4 load");
        wr(2'd3, 8'hE5, "R4 rotate fast vol5");
        run(60 * 4, 0, "R4 rotate repeats, no empty");
        wr(2'd3, 8'hA5, "R4 rotate off");
        run(30 * 4, 0, "R4 then drain R7");
        // Noise
        wr(2'd3, 8'hBF, "R5 noise fast vol15");
        run(80 * 4, 0, "R5 noise sequence");
        wr(2'd3, 8'h9C, "R5 noise slow vol12");
        run(64, 0, "R5 noise slow");
        // Mute freezes everything
        wr(2'd2, 8'hFF, "R6 load");
        wr(2'd3, 8'h2F, "R6 off fast");
        run(40, 0, "R6 muted and frozen");
        wr(2'd3, 8'hAF, "R6 back on");
        run(40, 0, "R6 resumes");
        // Interrupt gating while empty
        run(100, 0, "R7 drain");
        cyc(1'b0, 1'b0, 2'd0, 8'd0, 1'b0, "R8 irq gated off");
        cyc(1'b0, 1'b0, 2'd0, 8'd0, 1'b1, "R8 irq back on");
        cyc(1'b0, 1'b0, 2'd0, 8'd0, 1'b1, "R9 idle");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule